// File: doc/BRIEF.md
# Conditional Port-to-Port Move Sequencer

This block is the control core of a transport-triggered processor. Each instruction carries no opcode. It names a condition mask, a source port number and a destination port number. The block takes instructions from an instruction fetcher over a valid/ready stream. It tests the mask against a flags input. When the test passes, it moves one data word from the named source to the named destination across a shared internal bus.

The move uses a four-phase handshake with the port modules. The unit raises a read strobe with both port numbers on the bus. The addressed source answers with a handover signal once its word is stable. The addressed destination answers with a completion signal once it has taken the word. Either side may stall for any number of cycles. Once completion is seen, the unit drops the read strobe and waits for both handover and completion to return low. Only then does it ask the fetcher for the next word.

On the fetch stream, the fetcher may hold `instr_valid` low for as long as it likes. The unit raises `instr_ready` only when it can accept a new word. A word is taken on a cycle where both `instr_valid` and `instr_ready` are high. The fetcher must keep its word stable until that cycle.

Top module: `move_ctrl_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_read` is 0. From the first cycle after reset, `instr_ready` is 1.
- R2: An instruction executes when `(flags & mask) == mask`. A mask of all zeros therefore always executes. Flags are sampled on the cycle after the word is accepted.
- R3: When the mask test fails, the unit never raises `bus_read` for that instruction. `instr_ready` returns to 1 two cycles after the word was accepted.
- R4: The instruction word is laid out as mask in bits [15:12], source port in [11:6] and destination port in [5:0]. For an executed move, `bus_read` rises two cycles after acceptance. At that point `src_sel` and `dst_sel` carry the two port fields.
- R5: Once raised, `bus_read` stays high for as long as `bus_done` is low, however long the handover or completion is delayed.
- R6: `bus_read` falls on the cycle after `bus_done` is first seen high.
- R7: After `bus_read` falls, `instr_ready` stays 0 until both `bus_handover` and `bus_done` have been seen low. It rises on the cycle after that. `instr_ready` is never 1 while `bus_read` is 1.
- R8: A word is taken only on a cycle where `instr_valid` and `instr_ready` are both 1. `instr_ready` is 0 on the cycle after a word is taken. While `instr_valid` is low, the unit waits with `instr_ready` high and `bus_read` low.
- R9: `bus_data` equals `src_data` while `bus_read` and `bus_handover` are both high, and is all zeros otherwise.
- R10: `src_sel` and `dst_sel` do not change while `bus_read` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flags | input | MASK_W (4) | Condition flags compared with the mask |
| instr_valid | input | 1 | Fetcher has a word available |
| instr_ready | output | 1 | Unit accepts a word this cycle |
| instr_data | input | MASK_W+2*PORT_W (16) | Instruction word {mask, source, destination} |
| src_sel | output | PORT_W (6) | Source port number on the bus |
| dst_sel | output | PORT_W (6) | Destination port number on the bus |
| bus_read | output | 1 | Read strobe of the move handshake |
| bus_handover | input | 1 | Source reports that its data is stable |
| bus_done | input | 1 | Destination reports that it has taken the data |
| src_data | input | DATA_W (32) | Word offered by the source ports |
| bus_data | output | DATA_W (32) | Gated word delivered to the destination ports |

## Verification
The assertions assume well-behaved port partners. A source raises handover only while it is addressed, and holds handover until the read strobe falls. A destination raises completion only after handover, and holds it until the read strobe falls. The assertions also assume that flags stay steady from the accepting cycle through the evaluation cycle. The bench's model ports keep these rules: they raise handover after a chosen delay and completion after a further delay, and release them only once the read strobe is seen low. The bench changes flags only while the fetch word is being presented.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,  // waiting for an instruction word
    ST_EVAL  = 2'd1,  // mask tested against flags
    ST_XFER  = 2'd2,  // read strobe high, waiting for completion
    ST_RTZ   = 2'd3   // waiting for handover and completion to return low
  } mcu_state_e;
endpackage

// File: rtl/mcu_instr_reg.sv
module mcu_instr_reg #(
  parameter int MASK_W = 4,
  parameter int PORT_W = 6,
  localparam int INSTR_W = MASK_W + 2 * PORT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [INSTR_W-1:0] word,
  output logic [MASK_W-1:0]  mask,
  output logic [PORT_W-1:0]  src,
  output logic [PORT_W-1:0]  dst
);
  logic [INSTR_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else if (load) held <= word;
  end

  assign mask = held[INSTR_W-1 -: MASK_W];
  assign src  = held[2*PORT_W-1 -: PORT_W];
  assign dst  = held[PORT_W-1:0];
endmodule

// File: rtl/mcu_cond.sv
module mcu_cond #(
  parameter int MASK_W = 4
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [MASK_W-1:0] flags,
  output logic              match
);
  logic [MASK_W-1:0] bit_ok;

  // A bit passes if it is not demanded, or if the flag is set.
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    assign bit_ok[i] = ~mask[i] | flags[i];
  end

  assign match = &bit_ok;
endmodule

// File: rtl/mcu_seq.sv
module mcu_seq
  import mcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic instr_valid,
  input  logic match,
  input  logic handover,
  input  logic done,
  output logic instr_ready,
  output logic load,
  output logic read
);
  mcu_state_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FETCH;
    else state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FETCH: if (instr_valid) nxt = ST_EVAL;
      ST_EVAL:  nxt = match ? ST_XFER : ST_FETCH;
      ST_XFER:  if (done) nxt = ST_RTZ;
      ST_RTZ:   if (!handover && !done) nxt = ST_FETCH;
      default:  nxt = ST_FETCH;
    endcase
  end

  assign instr_ready = (state == ST_FETCH);
  assign load        = instr_ready && instr_valid;
  assign read        = (state == ST_XFER);
endmodule

// File: rtl/move_ctrl_unit.sv
module move_ctrl_unit #(
  parameter int MASK_W = 4,
  parameter int PORT_W = 6,
  parameter int DATA_W = 32,
  localparam int INSTR_W = MASK_W + 2 * PORT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MASK_W-1:0]  flags,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr_data,
  output logic [PORT_W-1:0]  src_sel,
  output logic [PORT_W-1:0]  dst_sel,
  output logic               bus_read,
  input  logic               bus_handover,
  input  logic               bus_done,
  input  logic [DATA_W-1:0]  src_data,
  output logic [DATA_W-1:0]  bus_data
);
  logic              load;
  logic              match;
  logic [MASK_W-1:0] cur_mask;

  mcu_instr_reg #(.MASK_W(MASK_W), .PORT_W(PORT_W)) u_ir (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .word  (instr_data),
    .mask  (cur_mask),
    .src   (src_sel),
    .dst   (dst_sel)
  );

  mcu_cond #(.MASK_W(MASK_W)) u_cond (
    .mask  (cur_mask),
    .flags (flags),
    .match (match)
  );

  mcu_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .match       (match),
    .handover    (bus_handover),
    .done        (bus_done),
    .instr_ready (instr_ready),
    .load        (load),
    .read        (bus_read)
  );

  // Only a word that the addressed source has declared stable reaches the bus.
  assign bus_data = (bus_read && bus_handover) ? src_data : '0;
endmodule

// File: rtl/move_ctrl_unit_chk.sv
module move_ctrl_unit_chk #(
  parameter int MASK_W = 4,
  parameter int PORT_W = 6,
  parameter int DATA_W = 32,
  localparam int INSTR_W = MASK_W + 2 * PORT_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [MASK_W-1:0]  flags,
  input logic               instr_valid,
  input logic               instr_ready,
  input logic [INSTR_W-1:0] instr_data,
  input logic [PORT_W-1:0]  src_sel,
  input logic [PORT_W-1:0]  dst_sel,
  input logic               bus_read,
  input logic               bus_handover,
  input logic               bus_done,
  input logic [DATA_W-1:0]  bus_data
);
  logic              took;
  logic [MASK_W-1:0] took_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      took      <= 1'b0;
      took_mask <= '0;
    end else begin
      took      <= instr_valid && instr_ready;
      took_mask <= instr_data[INSTR_W-1 -: MASK_W];
    end
  end

  p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    took && ((flags & took_mask) != took_mask) |=> !bus_read && instr_ready);

  p_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    took && ((flags & took_mask) == took_mask) |=> bus_read);

  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read && !bus_done |=> bus_read);

  p_read_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read && bus_done |=> !bus_read);

  p_no_fetch_in_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |-> !instr_ready);

  p_rtz_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_read && !instr_ready && (bus_handover || bus_done) |=> !instr_ready);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_ready |=> !instr_ready);

  p_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_read |-> bus_data == '0);

  p_sel_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read && $past(bus_read) |-> $stable(src_sel) && $stable(dst_sel));
endmodule

bind move_ctrl_unit move_ctrl_unit_chk #(
  .MASK_W(MASK_W), .PORT_W(PORT_W), .DATA_W(DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flags        (flags),
  .instr_valid  (instr_valid),
  .instr_ready  (instr_ready),
  .instr_data   (instr_data),
  .src_sel      (src_sel),
  .dst_sel      (dst_sel),
  .bus_read     (bus_read),
  .bus_handover (bus_handover),
  .bus_done     (bus_done),
  .bus_data     (bus_data)
);

// File: tb/move_ctrl_unit_test.sv
`timescale 1ns/1ps
module move_ctrl_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  flags = '0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr_data = '0;
  logic [5:0]  src_sel, dst_sel;
  logic        bus_read;
  logic        bus_handover = 1'b0;
  logic        bus_done = 1'b0;
  logic [31:0] src_data = '0;
  logic [31:0] bus_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  move_ctrl_unit uut (
    .clk(clk), .rst_n(rst_n), .flags(flags),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_data(instr_data),
    .src_sel(src_sel), .dst_sel(dst_sel), .bus_read(bus_read),
    .bus_handover(bus_handover), .bus_done(bus_done),
    .src_data(src_data), .bus_data(bus_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One instruction from fetch to return-to-zero, with model port delays.
  task automatic do_move(input logic [3:0] mask, input logic [5:0] src,
                         input logic [5:0] dst, input logic [3:0] fl,
                         input int hdly, input int ddly, input logic [31:0] word);
    bit exec;
    exec = ((fl & mask) == mask);                  // R2 rule
    check("R8 ready before offer", {31'd0, instr_ready}, 32'd1);
    instr_valid = 1'b1;
    instr_data  = {mask, src, dst};                 // R4 layout
    flags       = fl;
    @(negedge clk);
    instr_valid = 1'b0;
    check("R8 ready low after accept", {31'd0, instr_ready}, 32'd0);
    check("R2 no read in eval", {31'd0, bus_read}, 32'd0);
    @(negedge clk);
    if (!exec) begin
      check("R3 skipped move no read", {31'd0, bus_read}, 32'd0);
      check("R3 ready after skip", {31'd0, instr_ready}, 32'd1);
      return;
    end
    check("R2 R4 read raised", {31'd0, bus_read}, 32'd1);
    check("R4 src_sel", {26'd0, src_sel}, {26'd0, src});
    check("R4 dst_sel", {26'd0, dst_sel}, {26'd0, dst});
    for (int i = 0; i < hdly; i++) begin
      check("R9 bus quiet before handover", bus_data, 32'd0);
      @(negedge clk);
      check("R5 read held awaiting handover", {31'd0, bus_read}, 32'd1);
    end
    src_data     = word;
    bus_handover = 1'b1;
    #1;
    check("R9 bus carries source word", bus_data, word);
    for (int i = 0; i < ddly; i++) begin
      @(negedge clk);
      check("R5 read held awaiting done", {31'd0, bus_read}, 32'd1);
      check("R10 src_sel stable", {26'd0, src_sel}, {26'd0, src});
      check("R10 dst_sel stable", {26'd0, dst_sel}, {26'd0, dst});
    end
    @(negedge clk);
    bus_done = 1'b1;
    @(negedge clk);
    check("R6 read dropped after done", {31'd0, bus_read}, 32'd0);
    check("R9 bus quiet after read", bus_data, 32'd0);
    check("R7 no fetch while done high", {31'd0, instr_ready}, 32'd0);
    bus_handover = 1'b0;
    @(negedge clk);
    check("R7 no fetch while done still high", {31'd0, instr_ready}, 32'd0);
    bus_done = 1'b0;
    @(negedge clk);
    check("R7 fetch after return to zero", {31'd0, instr_ready}, 32'd1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 read low in reset", {31'd0, bus_read}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, instr_ready}, 32'd1);
    check("R1 read low after reset", {31'd0, bus_read}, 32'd0);
  endtask

  task automatic t_idle_wait();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 waits with ready high", {31'd0, instr_ready}, 32'd1);
      check("R8 no read while idle", {31'd0, bus_read}, 32'd0);
    end
  endtask

  task automatic t_zero_mask_fast();
    do_move(4'b0000, 6'd5, 6'd9, 4'b0000, 0, 0, 32'hA5A5_0001); // R2 zero mask
  endtask

  task automatic t_partial_match_slow();
    do_move(4'b1010, 6'd63, 6'd1, 4'b1110, 3, 4, 32'h1234_5678);
  endtask

  task automatic t_skip();
    do_move(4'b0011, 6'd7, 6'd8, 4'b0001, 0, 0, 32'h0);         // R3
    do_move(4'b1000, 6'd2, 6'd3, 4'b0111, 0, 0, 32'h0);         // R3
  endtask

  task automatic t_skip_then_exec();
    do_move(4'b0100, 6'd11, 6'd12, 4'b0000, 0, 0, 32'h0);
    do_move(4'b1111, 6'd42, 6'd21, 4'b1111, 1, 2, 32'hDEAD_BEEF);
  endtask

  initial begin
    t_reset();
    t_idle_wait();
    t_zero_mask_fast();
    t_partial_match_slow();
    t_skip();
    t_skip_then_exec();
    t_idle_wait();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule